// File: doc/BRIEF.md
# Descriptor-Driven Single DMA Channel

This block is one channel of a direct memory access engine. Software loads an eight-byte descriptor one byte at a time. The descriptor holds a source pointer, a destination pointer, a length and a set of mode fields. Software then arms the channel. While armed, the channel watches the trigger source chosen by the descriptor. On each trigger it copies data from the source pointer to the destination pointer over a byte-wide memory port with single-cycle access. After every unit, each pointer either stays put, steps forward by one unit, steps forward by two units, or steps back by one unit.

The number of units moved in a pass comes either from the descriptor length or from the first byte of the pass. When it comes from the first byte, an offset is added and the result is capped by the descriptor length. A trigger can move one unit or the whole remaining pass. At the end of a pass the channel either disarms or reloads itself and rearms. It also pulses a completion strobe, which can drive the next channel in a chain. If the descriptor allows it, the channel sets a sticky done flag.

Top module: `dmac_channel`

## Requirements
- R1: Descriptor byte layout, by write offset:
  - offsets 0 and 1: source pointer, low byte then high byte.
  - offsets 2 and 3: destination pointer, low byte then high byte.
  - offset 4: length bits 7:0.
  - offset 5: variable-length mode in [7:5] and length bits 12:8 in [4:0].
  - offset 6: transfer mode in [7:6], word size in [5] and trigger select in [4:0].
  - offset 7: source step in [7:6], destination step in [5:4], done-flag enable in [3], 7-bit count select in [2] and bus priority in [1:0].
  - After reset the descriptor is all zero, the channel is disarmed, the done flag is clear and no memory access is issued.
- R2: With variable-length mode 0, a pass moves exactly the descriptor length in units. In block mode (transfer mode 1) the whole pass is moved on a single trigger. A length of 0 completes the pass on the trigger with no memory access.
- R3: In single mode (transfer mode 0), each trigger moves one unit, so a pass of N units needs N triggers.
- R4: In variable-length modes, the first byte read sets the pass length:
  - mode 1: byte value plus 1.
  - mode 2: byte value.
  - mode 3: byte value plus 2.
  - mode 4: byte value plus 3.
  - modes 5 to 7: behave as mode 0.
- R5: When the 7-bit count select is 1, bit 7 of the first byte is ignored in the derived count. When it is 0, all eight bits count.
- R6: A derived count is limited to the descriptor length. It is never below one unit, because the first unit has already been moved.
- R7: Word size 0 moves one byte per unit. Word size 1 moves two bytes per unit: the byte at the source pointer goes to the destination pointer first, then the byte at pointer+1 goes to destination+1.
- R8: Step codes apply to each pointer after each unit: 0 holds, 1 adds one unit, 2 adds two units, 3 subtracts one unit. All pointer arithmetic wraps modulo 2^16.
- R9: Trigger select n uses bit n of the trigger vector. Bit 0 is the software request and bit 1 is the previous channel's completion. Select 31 never fires. A trigger while the channel is disarmed has no effect.
- R10: Transfer modes 2 (single) and 3 (block) stay armed after a pass. They reload the pointers and the count from the descriptor, so the next pass repeats the first.
- R11: Every pass end gives a one-cycle pulse on `chan_done`. Transfer modes 0 and 1 disarm at that point.
- R12: At pass end, `done_flag` is set only when the done-flag enable bit is 1. It stays set until `done_clr` is pulsed.
- R13: A control write with arm set and abort clear arms an idle channel and loads the pointers. A write with both arm and abort set disarms the channel and stops any transfer, with no later memory access. A write with abort alone does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Descriptor byte write strobe |
| cfg_addr | input | 3 | Descriptor byte offset |
| cfg_wdata | input | 8 | Descriptor byte value |
| ctl_we | input | 1 | Control write strobe |
| ctl_arm | input | 1 | Arm bit of the control write |
| ctl_abort | input | 1 | Abort bit of the control write |
| done_clr | input | 1 | Clears the done flag |
| trig_vec | input | 31 | Trigger sources, bit n for select n |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read byte address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | 16 | Memory write byte address |
| mem_wr_data | output | 8 | Memory write data |
| armed | output | 1 | Channel armed |
| chan_done | output | 1 | One-cycle pass-end strobe |
| done_flag | output | 1 | Sticky completion flag |
| bus_prio | output | 2 | Priority field presented to the bus arbiter |

## Verification
The bench uses the default parameters: a 13-bit length, 31 trigger inputs and 16-bit pointers. With this setup the capped derived count, select 31 (which has no source behind it) and pointer wrap across 0xFFFF all appear in directed cases. The bench memory model decodes only the low eight address bits. Every vector is placed so that its source and destination windows stay apart inside that 256-byte image, which lets the whole image be compared against a reference built from the requirements.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int PTR_W = 16;
  localparam int CNT_W = 13;

  localparam logic [1:0] STEP_HOLD = 2'd0;
  localparam logic [1:0] STEP_UP1  = 2'd1;
  localparam logic [1:0] STEP_UP2  = 2'd2;
  localparam logic [1:0] STEP_DN1  = 2'd3;

  typedef struct packed {
    logic [PTR_W-1:0] src;
    logic [PTR_W-1:0] dst;
    logic [CNT_W-1:0] len;
    logic [2:0]       vmode;
    logic [4:0]       trig;
    logic [1:0]       tmode;   // [0] block, [1] self-rearm
    logic             wide;
    logic [1:0]       sstep;
    logic [1:0]       dstep;
    logic             irq_en;
    logic             cnt7;
    logic [1:0]       prio;
  } desc_t;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p,
                                                input logic [1:0] code,
                                                input logic wide);
    logic [PTR_W-1:0] u;
    logic [PTR_W-1:0] r;
    u = wide ? PTR_W'(2) : PTR_W'(1);
    case (code)
      STEP_UP1: r = p + u;
      STEP_UP2: r = p + (u << 1);
      STEP_DN1: r = p - u;
      default:  r = p;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dmac_desc_regs.sv
module dmac_desc_regs
  import dmac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_we,
  input  logic [2:0] cfg_addr,
  input  logic [7:0] cfg_wdata,
  output desc_t      desc
);
  localparam int NB = 8;

  logic [7:0] bytes_q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) bytes_q[i] <= 8'h00;
      else if (cfg_we && cfg_addr == 3'(i)) bytes_q[i] <= cfg_wdata;
    end
  end

  always_comb begin
    desc.src    = {bytes_q[1], bytes_q[0]};
    desc.dst    = {bytes_q[3], bytes_q[2]};
    desc.len    = {bytes_q[5][4:0], bytes_q[4]};
    desc.vmode  = bytes_q[5][7:5];
    desc.tmode  = bytes_q[6][7:6];
    desc.wide   = bytes_q[6][5];
    desc.trig   = bytes_q[6][4:0];
    desc.sstep  = bytes_q[7][7:6];
    desc.dstep  = bytes_q[7][5:4];
    desc.irq_en = bytes_q[7][3];
    desc.cnt7   = bytes_q[7][2];
    desc.prio   = bytes_q[7][1:0];
  end

  // R1
  src_lo_load_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we && cfg_addr == 3'd0 |=> desc.src[7:0] == $past(cfg_wdata));

endmodule

// File: rtl/dmac_trig_mux.sv
module dmac_trig_mux #(
  parameter int N_TRIG = 31
) (
  input  logic [N_TRIG-1:0] trig_vec,
  input  logic [4:0]        sel,
  output logic              hit
);
  localparam int N_SEL = 32;

  logic [N_SEL-1:0] srcs;

  for (genvar i = 0; i < N_SEL; i++) begin : g_src
    if (i < N_TRIG) begin : g_live
      assign srcs[i] = trig_vec[i];
    end else begin : g_dead
      assign srcs[i] = 1'b0;
    end
  end

  assign hit = srcs[sel];

endmodule

// File: rtl/dmac_len_calc.sv
module dmac_len_calc #(
  parameter int LEN_W = 13
) (
  input  logic [7:0]       first_byte,
  input  logic [2:0]       vmode,
  input  logic             cnt7,
  input  logic [LEN_W-1:0] len_max,
  output logic [LEN_W-1:0] units
);
  localparam int DW = 10;

  logic [DW-1:0]    base;
  logic [DW-1:0]    derived;
  logic [LEN_W-1:0] capped;

  always_comb begin
    base = cnt7 ? {3'b000, first_byte[6:0]} : {2'b00, first_byte};
    case (vmode)
      3'd1:    derived = base + 10'd1;
      3'd3:    derived = base + 10'd2;
      3'd4:    derived = base + 10'd3;
      default: derived = base;
    endcase
    capped = (LEN_W'(derived) > len_max) ? len_max : LEN_W'(derived);
    units  = (capped == '0) ? LEN_W'(1) : capped;
  end

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int N_TRIG = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              ctl_we,
  input  logic              ctl_arm,
  input  logic              ctl_abort,
  input  logic              done_clr,
  input  logic [N_TRIG-1:0] trig_vec,
  output logic              mem_rd_en,
  output logic [PTR_W-1:0]  mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [PTR_W-1:0]  mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic              armed,
  output logic              chan_done,
  output logic              done_flag,
  output logic [1:0]        bus_prio
);
  typedef enum logic [1:0] {S_WAIT, S_RD, S_WR} state_e;

  desc_t            desc;
  state_e           state;
  logic [PTR_W-1:0] src_p, dst_p;
  logic [CNT_W-1:0] rem;
  logic             first;
  logic             bidx;
  logic             trig_hit;
  logic [CNT_W-1:0] len_units;
  logic             var_mode;
  logic [CNT_W-1:0] rem_cur;
  logic             last_byte;
  logic             arm_wr, abort_wr;
  logic [PTR_W-1:0] src_nx, dst_nx;

  dmac_desc_regs u_desc (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .desc(desc)
  );

  dmac_trig_mux #(.N_TRIG(N_TRIG)) u_trig (
    .trig_vec(trig_vec), .sel(desc.trig), .hit(trig_hit)
  );

  dmac_len_calc #(.LEN_W(CNT_W)) u_len (
    .first_byte(mem_rd_data), .vmode(desc.vmode), .cnt7(desc.cnt7),
    .len_max(desc.len), .units(len_units)
  );

  assign bus_prio  = desc.prio;
  assign arm_wr    = ctl_we && ctl_arm && !ctl_abort;
  assign abort_wr  = ctl_we && ctl_arm && ctl_abort;
  assign var_mode  = (desc.vmode != 3'd0) && (desc.vmode <= 3'd4);
  assign rem_cur   = (first && !bidx && var_mode) ? len_units : rem;
  assign last_byte = !desc.wide || bidx;
  assign src_nx    = step_ptr(src_p, desc.sstep, desc.wide);
  assign dst_nx    = step_ptr(dst_p, desc.dstep, desc.wide);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_WAIT;
      armed       <= 1'b0;
      src_p       <= '0;
      dst_p       <= '0;
      rem         <= '0;
      first       <= 1'b0;
      bidx        <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      chan_done   <= 1'b0;
      done_flag   <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      chan_done <= 1'b0;
      if (done_clr) done_flag <= 1'b0;
      if (abort_wr) begin
        armed <= 1'b0;
        state <= S_WAIT;
        bidx  <= 1'b0;
      end else begin
        case (state)
          S_WAIT: begin
            if (!armed && arm_wr) begin
              armed <= 1'b1;
              src_p <= desc.src;
              dst_p <= desc.dst;
              rem   <= desc.len;
              first <= 1'b1;
              bidx  <= 1'b0;
            end else if (armed && trig_hit) begin
              if (!(first && var_mode) && rem == '0) begin
                chan_done <= 1'b1;
                if (desc.irq_en) done_flag <= 1'b1;
                if (!desc.tmode[1]) armed <= 1'b0;
              end else begin
                mem_rd_en   <= 1'b1;
                mem_rd_addr <= src_p;
                state       <= S_RD;
              end
            end
          end
          S_RD: state <= S_WR;
          S_WR: begin
            mem_wr_en   <= 1'b1;
            mem_wr_addr <= dst_p + PTR_W'(bidx);
            mem_wr_data <= mem_rd_data;
            if (!last_byte) begin
              bidx        <= 1'b1;
              rem         <= rem_cur;
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= src_p + PTR_W'(1);
              state       <= S_RD;
            end else begin
              bidx  <= 1'b0;
              first <= 1'b0;
              src_p <= src_nx;
              dst_p <= dst_nx;
              rem   <= rem_cur - CNT_W'(1);
              if (rem_cur == CNT_W'(1)) begin
                state     <= S_WAIT;
                chan_done <= 1'b1;
                if (desc.irq_en) done_flag <= 1'b1;
                if (desc.tmode[1]) begin
                  src_p <= desc.src;
                  dst_p <= desc.dst;
                  rem   <= desc.len;
                  first <= 1'b1;
                end else begin
                  armed <= 1'b0;
                end
              end else if (desc.tmode[0]) begin
                mem_rd_en   <= 1'b1;
                mem_rd_addr <= src_nx;
                state       <= S_RD;
              end else begin
                state <= S_WAIT;
              end
            end
          end
          default: state <= S_WAIT;
        endcase
      end
    end
  end

  // R13
  abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_we && ctl_arm && ctl_abort |=> !armed && !mem_rd_en && !mem_wr_en);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    chan_done |=> !chan_done);

  // R11
  oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
    chan_done && !desc.tmode[1] |-> !armed);

  // R12
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done_flag && !done_clr |=> done_flag);

  // R12
  flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> chan_done);

  // R7
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> $past(mem_rd_en, 2));

  // R9
  rd_armed_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> armed);

endmodule

// File: tb/tb_dmac_channel.sv
`timescale 1ns/1ps
module tb_dmac_channel;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0;
  logic [7:0]  cfg_wdata = 0;
  logic        ctl_we = 0, ctl_arm = 0, ctl_abort = 0, done_clr = 0;
  logic [30:0] trig_vec = '0;
  logic        mem_rd_en, mem_wr_en;
  logic [15:0] mem_rd_addr, mem_wr_addr;
  logic [7:0]  mem_rd_data = 0, mem_wr_data;
  logic        armed, chan_done, done_flag;
  logic [1:0]  bus_prio;

  logic        tb_we = 0;
  logic [7:0]  tb_wa = 0, tb_wd = 0;
  logic [7:0]  mem [256];
  logic [7:0]  pre [256];
  logic [7:0]  expm [256];
  int wr_cnt = 0, rd_cnt = 0, done_cnt = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  dmac_channel dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ctl_we(ctl_we), .ctl_arm(ctl_arm), .ctl_abort(ctl_abort), .done_clr(done_clr),
    .trig_vec(trig_vec), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .armed(armed), .chan_done(chan_done),
    .done_flag(done_flag), .bus_prio(bus_prio)
  );

  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    else if (mem_wr_en) mem[mem_wr_addr[7:0]] <= mem_wr_data;
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[7:0]];
    if (mem_wr_en) wr_cnt <= wr_cnt + 1;
    if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    if (chan_done) done_cnt <= done_cnt + 1;
  end

  // fields: src, dst, len, first byte, vmode, tmode, wide, sstep, dstep, cnt7, irq_en
  localparam int NV = 16;
  localparam logic [59:0] VEC [NV] = '{
    {16'h1010, 16'h2090, 8'd6,  8'h00, 3'd0, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R2
    {16'h1010, 16'h2090, 8'd3,  8'h00, 3'd0, 2'd0, 1'b0, 2'd1, 2'd2, 1'b0, 1'b0}, // R3 R12
    {16'h3020, 16'h30A0, 8'd4,  8'h00, 3'd0, 2'd1, 1'b1, 2'd1, 2'd1, 1'b0, 1'b1}, // R7
    {16'h0010, 16'h0080, 8'd20, 8'h05, 3'd1, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R4
    {16'h0010, 16'h0080, 8'd20, 8'h05, 3'd2, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R4
    {16'h0010, 16'h0080, 8'd20, 8'h05, 3'd3, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R4
    {16'h0010, 16'h0080, 8'd20, 8'h05, 3'd4, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R4
    {16'h0010, 16'h0080, 8'd20, 8'h8A, 3'd1, 2'd1, 1'b0, 2'd1, 2'd1, 1'b1, 1'b1}, // R5
    {16'h0010, 16'h0080, 8'd20, 8'h8A, 3'd1, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R5 R6
    {16'h0010, 16'h0080, 8'd10, 8'd50, 3'd1, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R6
    {16'h0010, 16'h0080, 8'd10, 8'd0,  3'd2, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R6
    {16'h0010, 16'h0080, 8'd3,  8'd40, 3'd6, 2'd1, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R4
    {16'h0050, 16'hFFFE, 8'd4,  8'h00, 3'd0, 2'd1, 1'b0, 2'd3, 2'd1, 1'b0, 1'b1}, // R8
    {16'h0020, 16'h0090, 8'd3,  8'h00, 3'd0, 2'd1, 1'b0, 2'd0, 2'd1, 1'b0, 1'b1}, // R8
    {16'h0010, 16'h0080, 8'd2,  8'h00, 3'd0, 2'd2, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1}, // R10
    {16'h0010, 16'h0080, 8'd2,  8'h00, 3'd0, 2'd3, 1'b1, 2'd2, 2'd1, 1'b0, 1'b1}  // R10
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R2"; 1: return "R3"; 2: return "R7";
      3, 4, 5, 6, 11: return "R4"; 7, 8: return "R5"; 9, 10: return "R6";
      12, 13: return "R8"; default: return "R10";
    endcase
  endfunction

  function automatic int exp_units(int len, int f, int vm, bit c7);
    int d;
    if (vm == 0 || vm > 4) return len;
    d = c7 ? (f & 127) : f;
    d += (vm == 1) ? 1 : (vm == 2) ? 0 : (vm == 3) ? 2 : 3;
    if (d > len) d = len;
    if (d == 0) d = 1;
    return d;
  endfunction

  function automatic int step_amt(int code, int nb);
    case (code)
      1: return nb; 2: return 2 * nb; 3: return -nb; default: return 0;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic load_mem();
    for (int a = 0; a < 256; a++) begin
      tb_we = 1; tb_wa = 8'(a); tb_wd = pre[a]; tick();
    end
    tb_we = 0;
  endtask

  task automatic wr_desc(input logic [15:0] s, input logic [15:0] d, input logic [12:0] len,
                         input logic [2:0] vm, input logic [4:0] tg, input logic [1:0] tm,
                         input logic wd, input logic [1:0] ss, input logic [1:0] ds,
                         input logic c7, input logic ie);
    logic [7:0] b [8];
    b[0] = s[7:0]; b[1] = s[15:8]; b[2] = d[7:0]; b[3] = d[15:8];
    b[4] = len[7:0]; b[5] = {vm, len[12:8]}; b[6] = {tm, wd, tg};
    b[7] = {ss, ds, ie, c7, 2'b10};
    for (int i = 0; i < 8; i++) begin
      cfg_we = 1; cfg_addr = 3'(i); cfg_wdata = b[i]; tick();
    end
    cfg_we = 0;
  endtask

  task automatic ctl(input logic a, input logic ab);
    ctl_we = 1; ctl_arm = a; ctl_abort = ab; tick();
    ctl_we = 0; ctl_arm = 0; ctl_abort = 0;
  endtask

  task automatic clr_done(); done_clr = 1; tick(); done_clr = 0; endtask

  task automatic pulse(input int bitn);
    trig_vec[bitn] = 1'b1; tick(); trig_vec = '0;
  endtask

  task automatic run_pass(input bit blk, output int trigs, output bit got);
    got = 0; trigs = 0;
    while (!got && trigs < 300) begin
      pulse(0); trigs++;
      for (int c = 0; c < (blk ? 1200 : 8) && !got; c++) begin
        if (chan_done) got = 1;
        tick();
      end
    end
  endtask

  task automatic wait_n(input int n); for (int i = 0; i < n; i++) tick(); endtask

  initial begin
    repeat (190000) @(posedge clk);
    $display("FAIL watchdog (R1..all): actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
    $finish;
  end

  initial begin
    int trigs, n, bad, s, d, nb, w0, r0, d0;
    bit got;
    logic [59:0] v;
    rst = 1; wait_n(4); rst = 0; tick();
    // R1 reset state
    chk(!armed && !done_flag && !mem_rd_en && !mem_wr_en && !chan_done, "R1", "reset outputs",
        {armed, done_flag, mem_rd_en, mem_wr_en, chan_done}, 0);
    chk(bus_prio == 2'd0, "R1", "reset priority", bus_prio, 0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      for (int a = 0; a < 256; a++) pre[a] = 8'((a * 37 + 11) & 255);
      if (v[11:9] != 0) pre[v[59:44] & 16'hFF] = v[19:12];
      load_mem();
      wr_desc(v[59:44], v[43:28], {5'd0, v[27:20]}, v[11:9], 5'd0, v[8:7], v[6],
              v[5:4], v[3:2], v[1], v[0]);
      chk(bus_prio == 2'b10, "R1", "priority field", bus_prio, 2);
      clr_done();
      ctl(1, 0);
      n = exp_units(int'(v[27:20]), int'(v[19:12]), int'(v[11:9]), v[1]);
      nb = v[6] ? 2 : 1;
      for (int a = 0; a < 256; a++) expm[a] = pre[a];
      s = int'(v[59:44]); d = int'(v[43:28]);
      for (int u = 0; u < n; u++) begin
        for (int b = 0; b < nb; b++) expm[(d + b) & 255] = pre[(s + b) & 255];
        s += step_amt(int'(v[5:4]), nb); d += step_amt(int'(v[3:2]), nb);
      end
      for (int pass = 0; pass < (v[8] ? 2 : 1); pass++) begin
        if (pass == 1) load_mem();
        run_pass(v[7], trigs, got);
        wait_n(2);
        bad = 0;
        for (int a = 0; a < 256; a++) if (mem[a] !== expm[a]) bad++;
        chk(got && bad == 0, vtag(i), $sformatf("vector %0d pass %0d bytes wrong", i, pass), bad, 0);
        chk(trigs == (v[7] ? 1 : n), vtag(i), $sformatf("vector %0d triggers used", i), trigs,
            v[7] ? 1 : n);
        // R12 flag follows enable; R10/R11 armed state after pass
        chk(done_flag == v[0], "R12", $sformatf("vector %0d done flag", i), done_flag, v[0]);
        chk(armed == v[8], v[8] ? "R10" : "R11", $sformatf("vector %0d armed after pass", i),
            armed, v[8]);
      end
      ctl(1, 1);
    end

    // R12 flag held then cleared
    wr_desc(16'h0010, 16'h0080, 13'd1, 3'd0, 5'd0, 2'd1, 0, 2'd1, 2'd1, 0, 1);
    clr_done(); ctl(1, 0); run_pass(1, trigs, got); wait_n(5);
    chk(done_flag, "R12", "flag held", done_flag, 1);
    clr_done();
    chk(!done_flag, "R12", "flag cleared", done_flag, 0);

    // R2 zero length: completes with no memory access; R11 single-cycle strobe
    wr_desc(16'h0010, 16'h0080, 13'd0, 3'd0, 5'd0, 2'd1, 0, 2'd1, 2'd1, 0, 1);
    ctl(1, 0); r0 = rd_cnt; pulse(0);
    chk(chan_done, "R2", "zero length strobe", chan_done, 1);
    tick();
    chk(!chan_done, "R11", "strobe width", chan_done, 0);
    chk(rd_cnt == r0 && !armed, "R2", "zero length reads", rd_cnt - r0, 0);

    // R9 trigger selection
    wr_desc(16'h0010, 16'h0080, 13'd1, 3'd0, 5'd1, 2'd1, 0, 2'd1, 2'd1, 0, 0);
    ctl(1, 0); d0 = done_cnt; pulse(0); wait_n(8);
    chk(done_cnt == d0, "R9", "select 1 ignores software bit", done_cnt - d0, 0);
    pulse(1); wait_n(8);
    chk(done_cnt == d0 + 1 && !armed, "R9", "select 1 fires on chain bit", done_cnt - d0, 1);
    wr_desc(16'h0010, 16'h0080, 13'd1, 3'd0, 5'd17, 2'd1, 0, 2'd1, 2'd1, 0, 0);
    ctl(1, 0); d0 = done_cnt; pulse(16); wait_n(8);
    chk(done_cnt == d0, "R9", "select 17 ignores bit 16", done_cnt - d0, 0);
    pulse(17); wait_n(8);
    chk(done_cnt == d0 + 1, "R9", "select 17 fires", done_cnt - d0, 1);
    wr_desc(16'h0010, 16'h0080, 13'd1, 3'd0, 5'd31, 2'd1, 0, 2'd1, 2'd1, 0, 0);
    ctl(1, 0); r0 = rd_cnt;
    trig_vec = '1; tick(); trig_vec = '0; wait_n(8);
    chk(rd_cnt == r0 && armed, "R9", "select 31 never fires", rd_cnt - r0, 0);
    ctl(1, 1);

    // R9 disarmed channel ignores trigger; R13 abort alone does nothing
    wr_desc(16'h0010, 16'h0080, 13'd2, 3'd0, 5'd0, 2'd1, 0, 2'd1, 2'd1, 0, 0);
    ctl(0, 1);
    chk(!armed, "R13", "abort-only write keeps idle", armed, 0);
    r0 = rd_cnt; pulse(0); wait_n(8);
    chk(rd_cnt == r0, "R9", "trigger while disarmed", rd_cnt - r0, 0);

    // R13 abort mid-block
    wr_desc(16'h0010, 16'h0080, 13'd50, 3'd0, 5'd0, 2'd1, 0, 2'd1, 2'd1, 0, 1);
    clr_done(); ctl(1, 0);
    chk(armed, "R13", "arm write", armed, 1);
    pulse(0); wait_n(10);
    ctl(1, 1);
    w0 = wr_cnt;
    chk(!armed, "R13", "abort disarms", armed, 0);
    pulse(0); wait_n(20);
    chk(wr_cnt == w0, "R13", "no writes after abort", wr_cnt - w0, 0);
    chk(w0 > 0 && w0 < 10000 && !done_flag, "R13", "abort before pass end", done_flag, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule